// File: doc/BRIEF.md
# Space-Vector PWM Switching Sequencer

This block times the switching states of a three-phase bridge over one modulation period. A free-running period counter is compared with four cumulative thresholds, and these split the period into five intervals. The intervals apply the pattern zero, first active vector, second active vector, first active vector, zero. The selected 3-bit state is decoded into complementary high-side and low-side gate levels for the three phase legs. Dead-time insertion is left to a later stage.

The controller supplies two active vector codes and three dwell fractions, then pulses `load_i`. The block turns the fractions into thresholds as it captures them into a shadow plan. The shadow plan becomes the active plan only at the next counter wrap, so a period always runs with one consistent set of vectors and thresholds.

The segment state machine has six states. `SEG_IDLE` is held through reset and drives every gate off. After reset it leaves to whichever segment the count selects. `SEG_ZERO_LEAD` moves to `SEG_ACT_A` when the count reaches the first threshold. `SEG_ACT_A` moves to `SEG_ACT_B` at the second threshold. `SEG_ACT_B` moves to `SEG_ACT_A_RET` at the third threshold. `SEG_ACT_A_RET` moves to `SEG_ZERO_TAIL` at the fourth threshold. At the counter wrap, any state returns to `SEG_ZERO_LEAD`. When a threshold collapses an interval to zero length, the transition skips forward past every interval of zero length.

Top module: `svpwm_sequencer`

## Requirements
- R1: While reset is asserted, all six gate outputs and the tick are low.
- R2: The period count runs 0, 1, … 14399 and then returns to 0. `tick_o` is high for exactly the one cycle in which the count is 0 after a wrap. It is not high in the first period after reset.
- R3: Dwell fractions are unsigned 12-bit values, with 4096 representing one full period. The thresholds are computed as follows. The first threshold is floor(Tz·14399/8192). The second adds floor(Ta·14399/8192). The third adds floor(Tb·14399/4096). The fourth adds floor(Ta·14399/8192) again.
- R4: Let c be the count. If c is below the first threshold, the zero state applies. Below the second, the first vector applies. Below the third, the second vector applies. Below the fourth, the first vector applies again. Otherwise the zero state applies. Intervals of zero length are skipped. The gates reflect the count value of the same cycle.
- R5: The state bits map to phases as bit 2 = U, bit 1 = V and bit 0 = W. A bit of 1 turns the high side on and the low side off; a bit of 0 does the reverse. Code 000 turns on all low sides, and code 111 turns on all high sides.
- R6: From reset release until the first wrap, the zero state (000) is driven.
- R7: Inputs are captured on a `load_i` cycle and take effect only from the next wrap. A later load in the same period replaces an earlier one. A load in the cycle whose count is 14399 takes effect one period later.
- R8: In no cycle are the high side and low side of the same phase both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture strobe for vectors and dwell fractions |
| vec_first_i | input | 3 | First active state code |
| vec_second_i | input | 3 | Second active state code |
| dwell_zero_i | input | 12 | Zero-state dwell fraction (split into two halves) |
| dwell_first_i | input | 12 | First-vector dwell fraction (split into two halves) |
| dwell_second_i | input | 12 | Second-vector dwell fraction |
| tick_o | output | 1 | Period-start pulse |
| u_hi_o | output | 1 | Phase U high-side gate |
| u_lo_o | output | 1 | Phase U low-side gate |
| v_hi_o | output | 1 | Phase V high-side gate |
| v_lo_o | output | 1 | Phase V low-side gate |
| w_hi_o | output | 1 | Phase V/W high-side gate for W |
| w_lo_o | output | 1 | Phase W low-side gate |

## Verification
A counter that is off by one shows up at once as a tick in the wrong cycle. It also moves every segment edge by one count, so the gates are wrong in the first boundary cycle. A wrong threshold or a wrong segment state makes the gate levels diverge from the bench model in the very cycle the count crosses the affected boundary. A fault in the shadow-to-active transfer is only visible at the next wrap, up to one full period (14400 cycles) after the load. For this reason the bench compares the outputs on every cycle, across several periods with loads placed early, late and on the wrap cycle itself.

// File: rtl/svpwm_seq_pkg.sv
package svpwm_seq_pkg;

    localparam int PHASES = 3;

    typedef logic [PHASES-1:0] vec_t;

    typedef enum logic [2:0] {
        SEG_IDLE      = 3'd0,
        SEG_ZERO_LEAD = 3'd1,
        SEG_ACT_A     = 3'd2,
        SEG_ACT_B     = 3'd3,
        SEG_ACT_A_RET = 3'd4,
        SEG_ZERO_TAIL = 3'd5
    } seg_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

endpackage

// File: rtl/svpwm_threshold_calc.sv
module svpwm_threshold_calc #(
    parameter int PERIOD_MAX = 14399,
    parameter int FRAC_W     = 12,
    parameter int TH_W       = 16
) (
    input  logic [FRAC_W-1:0] dwell_zero_i,
    input  logic [FRAC_W-1:0] dwell_first_i,
    input  logic [FRAC_W-1:0] dwell_second_i,
    output logic [TH_W-1:0]   th_o [4]
);
    localparam int PW = FRAC_W + TH_W;
    localparam logic [PW-1:0] SCALE = PW'(PERIOD_MAX);

    logic [PW-1:0] prod_zero;
    logic [PW-1:0] prod_first;
    logic [PW-1:0] prod_second;
    logic [TH_W-1:0] half_zero;
    logic [TH_W-1:0] half_first;
    logic [TH_W-1:0] full_second;

    // scale each fraction to counts; halves drop one extra bit
    assign prod_zero   = PW'(dwell_zero_i)   * SCALE;
    assign prod_first  = PW'(dwell_first_i)  * SCALE;
    assign prod_second = PW'(dwell_second_i) * SCALE;

    assign half_zero   = TH_W'(prod_zero   >> (FRAC_W + 1));
    assign half_first  = TH_W'(prod_first  >> (FRAC_W + 1));
    assign full_second = TH_W'(prod_second >> FRAC_W);

    // cumulative edges: zero/2, +first/2, +second, +first/2
    assign th_o[0] = half_zero;
    assign th_o[1] = th_o[0] + half_first;
    assign th_o[2] = th_o[1] + full_second;
    assign th_o[3] = th_o[2] + half_first;

endmodule

// File: rtl/svpwm_period_counter.sv
module svpwm_period_counter #(
    parameter int PERIOD_MAX = 14399,
    parameter int CNT_W      = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_MAX);

    assign wrap_o = (cnt_o == LAST);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (wrap_o) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // R2
    wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_o == '0));

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_o |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/svpwm_gate_decoder.sv
module svpwm_gate_decoder
    import svpwm_seq_pkg::*;
(
    input  vec_t                   vec_i,
    input  logic                   enable_i,
    output leg_t [PHASES-1:0]      legs_o
);
    // index 2 = U, 1 = V, 0 = W; a set bit selects the high side
    for (genvar g = 0; g < PHASES; g++) begin : g_leg
        assign legs_o[g].hi = enable_i &  vec_i[g];
        assign legs_o[g].lo = enable_i & ~vec_i[g];
    end

endmodule

// File: rtl/svpwm_sequencer.sv
module svpwm_sequencer
    import svpwm_seq_pkg::*;
#(
    parameter int PERIOD_MAX = 14399,
    parameter int FRAC_W     = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [2:0]        vec_first_i,
    input  logic [2:0]        vec_second_i,
    input  logic [FRAC_W-1:0] dwell_zero_i,
    input  logic [FRAC_W-1:0] dwell_first_i,
    input  logic [FRAC_W-1:0] dwell_second_i,
    output logic              tick_o,
    output logic              u_hi_o,
    output logic              u_lo_o,
    output logic              v_hi_o,
    output logic              v_lo_o,
    output logic              w_hi_o,
    output logic              w_lo_o
);
    localparam int CNT_W = $clog2(PERIOD_MAX + 1);
    localparam int TH_W  = CNT_W + 2;

    typedef logic [TH_W-1:0] th_t;

    typedef struct packed {
        vec_t v1;
        vec_t v2;
        th_t  th1;
        th_t  th2;
        th_t  th3;
        th_t  th4;
    } plan_t;

    localparam th_t   NEVER      = th_t'(PERIOD_MAX + 1);
    localparam plan_t PLAN_RESET = '{v1: '0, v2: '0, th1: NEVER, th2: NEVER, th3: NEVER, th4: NEVER};

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              wrap;
    th_t               th_calc [4];
    plan_t             shadow_q;
    plan_t             active_q;
    plan_t             plan_nxt;
    seg_e              seg_q;
    seg_e              seg_d;
    vec_t              vec_d;
    leg_t [PHASES-1:0] legs_d;
    leg_t [PHASES-1:0] legs_q;
    logic              tick_q;

    svpwm_threshold_calc #(
        .PERIOD_MAX (PERIOD_MAX),
        .FRAC_W     (FRAC_W),
        .TH_W       (TH_W)
    ) u_thr (
        .dwell_zero_i   (dwell_zero_i),
        .dwell_first_i  (dwell_first_i),
        .dwell_second_i (dwell_second_i),
        .th_o           (th_calc)
    );

    svpwm_period_counter #(
        .PERIOD_MAX (PERIOD_MAX),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    // shadow plan: captured on every load strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shadow_q <= PLAN_RESET;
        end else if (load_i) begin
            shadow_q <= '{v1: vec_first_i, v2: vec_second_i,
                          th1: th_calc[0], th2: th_calc[1],
                          th3: th_calc[2], th4: th_calc[3]};
        end
    end

    // active plan: refreshed only at the period boundary
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= PLAN_RESET;
        end else if (wrap) begin
            active_q <= shadow_q;
        end
    end

    // view of the coming cycle, so the registered gates line up with the count
    assign cnt_nxt  = wrap ? '0 : cnt + CNT_W'(1);
    assign plan_nxt = wrap ? shadow_q : active_q;

    function automatic seg_e locate(input logic [CNT_W-1:0] c, input plan_t p);
        th_t cx;
        cx = th_t'(c);
        if (cx < p.th1)      return SEG_ZERO_LEAD;
        else if (cx < p.th2) return SEG_ACT_A;
        else if (cx < p.th3) return SEG_ACT_B;
        else if (cx < p.th4) return SEG_ACT_A_RET;
        else                 return SEG_ZERO_TAIL;
    endfunction

    // next segment: every state advances to wherever the coming count falls,
    // which skips any interval of zero length and restarts at the wrap
    always_comb begin
        seg_d = seg_q;
        unique case (seg_q)
            SEG_IDLE:      seg_d = locate(cnt_nxt, plan_nxt);
            SEG_ZERO_LEAD: seg_d = locate(cnt_nxt, plan_nxt);
            SEG_ACT_A:     seg_d = locate(cnt_nxt, plan_nxt);
            SEG_ACT_B:     seg_d = locate(cnt_nxt, plan_nxt);
            SEG_ACT_A_RET: seg_d = locate(cnt_nxt, plan_nxt);
            SEG_ZERO_TAIL: seg_d = locate(cnt_nxt, plan_nxt);
            default:       seg_d = SEG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seg_q <= SEG_IDLE;
        end else begin
            seg_q <= seg_d;
        end
    end

    // vector applied in each segment
    always_comb begin
        vec_d = '0;
        unique case (seg_d)
            SEG_IDLE:      vec_d = '0;
            SEG_ZERO_LEAD: vec_d = '0;
            SEG_ACT_A:     vec_d = plan_nxt.v1;
            SEG_ACT_B:     vec_d = plan_nxt.v2;
            SEG_ACT_A_RET: vec_d = plan_nxt.v1;
            SEG_ZERO_TAIL: vec_d = '0;
            default:       vec_d = '0;
        endcase
    end

    svpwm_gate_decoder u_dec (
        .vec_i    (vec_d),
        .enable_i (seg_d != SEG_IDLE),
        .legs_o   (legs_d)
    );

    // output register: gates and tick
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            legs_q <= '0;
            tick_q <= 1'b0;
        end else begin
            legs_q <= legs_d;
            tick_q <= wrap;
        end
    end

    assign tick_o = tick_q;
    assign u_hi_o = legs_q[2].hi;
    assign u_lo_o = legs_q[2].lo;
    assign v_hi_o = legs_q[1].hi;
    assign v_lo_o = legs_q[1].lo;
    assign w_hi_o = legs_q[0].hi;
    assign w_lo_o = legs_q[0].lo;

    // R2
    tick_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (cnt == '0));

    // R7
    plan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(active_q));

    // R8
    leg_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(u_hi_o && u_lo_o) && !(v_hi_o && v_lo_o) && !(w_hi_o && w_lo_o));

    // R4
    zero_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q == SEG_ZERO_LEAD || seg_q == SEG_ZERO_TAIL)
            |-> (u_lo_o && v_lo_o && w_lo_o && !u_hi_o && !v_hi_o && !w_hi_o));

    // R6
    idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q == SEG_IDLE) |=> (seg_q != SEG_IDLE));

endmodule

// File: tb/svpwm_sequencer_test.sv
module svpwm_sequencer_test;

    localparam int PMAX = 14399;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [2:0]  v1_in = '0;
    logic [2:0]  v2_in = '0;
    logic [11:0] dz_in = '0;
    logic [11:0] da_in = '0;
    logic [11:0] db_in = '0;
    logic        tick;
    logic        uh, ul, vh, vl, wh, wl;

    always #2 clk = ~clk;

    svpwm_sequencer uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .load_i         (load),
        .vec_first_i    (v1_in),
        .vec_second_i   (v2_in),
        .dwell_zero_i   (dz_in),
        .dwell_first_i  (da_in),
        .dwell_second_i (db_in),
        .tick_o         (tick),
        .u_hi_o         (uh),
        .u_lo_o         (ul),
        .v_hi_o         (vh),
        .v_lo_o         (vl),
        .w_hi_o         (wh),
        .w_lo_o         (wl)
    );

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    // bench model: [0]=v1 [1]=v2 [2..5]=cumulative edges
    int  m_cnt;
    int  m_sh [6];
    int  m_ac [6];
    bit  m_wrapped;
    bit  m_wrap;

    function automatic int half_cnt(input int d);
        return (d * PMAX) >> 13;
    endfunction

    function automatic int full_cnt(input int d);
        return (d * PMAX) >> 12;
    endfunction

    function automatic int seg_vec(input int c);
        if (c < m_ac[2]) return 0;
        if (c < m_ac[3]) return m_ac[0];
        if (c < m_ac[4]) return m_ac[1];
        if (c < m_ac[5]) return m_ac[0];
        return 0;
    endfunction

    function automatic logic [5:0] gates_of(input int v);
        logic [2:0] b;
        b = v[2:0];
        return {b[2], ~b[2], b[1], ~b[1], b[0], ~b[0]};
    endfunction

    function automatic bit plan_pending();
        for (int i = 0; i < 6; i++) if (m_sh[i] != m_ac[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        m_cnt = 0;
        m_wrapped = 0;
        m_wrap = 0;
        for (int i = 0; i < 6; i++) begin
            m_sh[i] = (i < 2) ? 0 : PMAX + 1;
            m_ac[i] = m_sh[i];
        end
    endtask

    task automatic check_reset_outputs(input string when);
        n_checks++;
        if ({uh, ul, vh, vl, wh, wl, tick} != 7'b0) begin
            n_bad++;
            $display("FAIL R1 %s: got gates=%b tick=%b exp gates=000000 tick=0",
                     when, {uh, ul, vh, vl, wh, wl}, tick);
        end
    endtask

    // one clock: drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(input bit ld);
        logic [5:0] exp_g;
        logic [5:0] got_g;
        int ev;
        string tag;
        load = ld;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        m_wrap = (m_cnt == PMAX);
        if (m_wrap) begin
            for (int i = 0; i < 6; i++) m_ac[i] = m_sh[i];
            m_wrapped = 1;
        end
        if (ld) begin
            m_sh[0] = v1_in;
            m_sh[1] = v2_in;
            m_sh[2] = half_cnt(dz_in);
            m_sh[3] = m_sh[2] + half_cnt(da_in);
            m_sh[4] = m_sh[3] + full_cnt(db_in);
            m_sh[5] = m_sh[4] + half_cnt(da_in);
        end
        m_cnt = m_wrap ? 0 : m_cnt + 1;
        ev = seg_vec(m_cnt);
        exp_g = gates_of(ev);
        got_g = {uh, ul, vh, vl, wh, wl};
        if (plan_pending()) tag = "R7";
        else if (!m_wrapped) tag = "R6";
        else if (m_cnt == m_ac[2] || m_cnt == m_ac[3] || m_cnt == m_ac[4] || m_cnt == m_ac[5]) tag = "R3";
        else if (ev == 0 || ev == 7) tag = "R5";
        else tag = "R4";
        n_checks++;
        if (got_g != exp_g) begin
            n_bad++;
            $display("FAIL %s gates at count %0d: got %b exp %b", tag, m_cnt, got_g, exp_g);
        end
        n_checks++;
        if (tick != m_wrap) begin
            n_bad++;
            $display("FAIL R2 tick at count %0d: got %b exp %b", m_cnt, tick, m_wrap);
        end
        n_checks++;
        if ((uh && ul) || (vh && vl) || (wh && wl)) begin
            n_bad++;
            $display("FAIL R8 leg overlap at count %0d: got %b exp no pair high", m_cnt, got_g);
        end
    endtask

    task automatic set_plan(input int a, input int b, input int z, input int f, input int s);
        v1_in = a[2:0];
        v2_in = b[2:0];
        dz_in = z[11:0];
        da_in = f[11:0];
        db_in = s[11:0];
    endtask

    task automatic set_random_plan();
        int z, f, s;
        z = $urandom % 4096;
        f = $urandom % (4096 - z);
        s = $urandom % (4096 - z - f);
        set_plan($urandom % 8, $urandom % 8, z, f, s);
    endtask

    function automatic void summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
    endfunction

    initial begin
        int wraps;
        int cur;
        int rp6;
        int rp7;
        bit ld;
        void'($urandom(32'h5eed_0042));
        rp6 = $urandom % (PMAX + 1);
        rp7 = $urandom % (PMAX + 1);
        model_reset();
        // R1: outputs low while reset is held, even with a load strobe present
        set_plan(7, 7, 100, 100, 100);
        load = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs("in reset");
        load = 1'b0;
        rst_n = 1'b1;
        check_reset_outputs("after release before first edge");
        wraps = 0;
        while (wraps < 9) begin
            cur = m_cnt;
            ld = 0;
            case (wraps)
                0: if (cur == 100) begin set_plan(4, 6, 1000, 1200, 800); ld = 1; end
                1: if (cur == 500) begin set_plan(2, 3, 0, 2000, 1000); ld = 1; end     // V1 from count 0
                2: if (cur == 7000) begin set_plan(1, 5, 1500, 0, 2000); ld = 1; end   // V1 intervals empty
                3: if (cur == 20) begin set_plan(7, 0, 1365, 1365, 1365); ld = 1; end  // 111 and 000
                4: begin
                    if (cur == 200) begin set_random_plan(); ld = 1; end
                    if (cur == 9000) begin set_plan(6, 4, 4095, 0, 0); ld = 1; end     // last load wins
                end
                5: if (cur == PMAX) begin set_plan(5, 1, 400, 1600, 1800); ld = 1; end // load on wrap cycle
                6: if (cur == rp6) begin set_random_plan(); ld = 1; end
                7: if (cur == rp7) begin set_random_plan(); ld = 1; end
                default: ld = 0;
            endcase
            step(ld);
            if (m_wrap) wraps++;
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
            summary();
            $finish;
        end
    end

endmodule